// File: doc/BRIEF.md
# Serial Gigabit PHY Bring-Up Sequencer

This block is a synchronous controller that takes a serial gigabit PHY from reset to an operational state. Each step of the controller either issues a reset pulse or a configuration-load strobe, or it waits on a status flag from the analog side. The flags are IO enable, calibration complete, PLL lock and DLL lock. Once the clocks are locked, the controller turns on the MAC clocks in gigabit/ten-bit mode. It then classifies the silicon from a revision flag and a 7-bit DLL delay code, drives a matching pair of receive eye thresholds to every channel, and resets the receive lanes.

On newer silicon the controller waits for the lanes to settle and then compares a reference pcode against a threshold. If the pcode is too low, it applies an alternate threshold pair and resets the lanes a second time. When no channel is enabled, a short power-off sequence runs in place of the full bring-up. The analog PHY, the PLL and the register bus lie outside the block and are reached through plain ports. The controller advances one step per pulse of a tick enable, so the integrator sets real time by choosing the tick rate.

Top module: `sgmii_bringup_seq`

## Requirements
- R1: While reset is held and immediately after it, setup_done_o, cal_lock_o, mac_mode_o, variant_o and both threshold buses are all zero, and no strobe is active.
- R2: When chan_en_i is all zero, the controller issues four events and then sets setup_done_o. The events, in order, are: soft-reset word 0x101, soft-reset word 0x001, a configuration-load pulse, and a DLL reset pulse with no lane-pair strobe.
- R3: When any bit of chan_en_i is set, the controller issues soft-reset word 0x101, then soft-reset word 0x001, then a configuration-load pulse. It then waits with no further event until io_en_i is high. In the soft-reset word, bit 8 is the peripheral reset and bit 0 is the non-volatile reset.
- R4: After the tick that accepts io_en_i, a ramp wait consumes 15 ticks. With a tick on every cycle, the DLL reset of the IO setup step appears 16 cycles after the accepting cycle.
- R5: IO setup issues its events in this order: the DLL reset together with every lane-pair reset strobe, then control word 0x047F, then control word 0x007F, then one calibrator reset pulse. In the control word, bits 6:0 are held at 0x7F and bit 10 is the calibrator peripheral reset.
- R6: The controller waits for cal_done_i and then sets cal_lock_o, which stays set. It then pulses pll_cfg_o and waits for pll_lock_i, then for dll_lock_i. Only after that does it set mac_mode_o to all ones. In mac_mode_o, each MAC m has gigabit at bit 2m and ten-bit mode at bit 2m+1.
- R7: Classification issues one threshold write. With rev_new_i set, variant_o becomes 3 and the threshold pair is the newer pre-test pair (late 6, early 1). Otherwise a DLL code below 13 gives variant 1 with late 2, early 5, and a code of 13 or more gives variant 2 with late 4, early 3. Channel c carries its value in bits 3c+2:3c of each threshold bus.
- R8: The lane reset issues control word 0x607F (bits 13 and 14 set) and then control word 0x007F.
- R9: On variants 1 and 2, setup_done_o rises one tick after the second lane-reset word.
- R10: On variant 3, a settle wait of 4095 ticks follows the lane reset, and the result check happens on the next tick. If ref_pcode_i is above 40, setup_done_o rises on the tick after the check. Otherwise, including a pcode equal to 40, the check writes the alternate pair (late 7, early 2), repeats both lane-reset words, and then sets setup_done_o.
- R11: Once set, setup_done_o stays high until reset, and no strobe is issued while it is high.
- R12: At most one step is taken per tick_i pulse, and no strobe is active in a cycle where tick_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Step enable; one step per high cycle |
| chan_en_i | input | CHEN_W | Channel-enable configuration; all zero selects the off sequence |
| io_en_i | input | 1 | IO enable from the bank power detector |
| cal_done_i | input | 1 | Calibration complete |
| pll_lock_i | input | 1 | PLL lock |
| dll_lock_i | input | 1 | DLL lock |
| dll_code_i | input | 7 | DLL 90-degree delay code |
| rev_new_i | input | 1 | Newer silicon revision flag |
| ref_pcode_i | input | PCODE_W | Reference pcode for the result check |
| sr_wr_o | output | 1 | Soft-reset word write strobe |
| sr_word_o | output | 9 | Soft-reset word (bit 8 peripheral, bit 0 non-volatile) |
| cfg_load_o | output | 1 | Configuration-load strobe |
| dll_rst_o | output | 1 | DLL reset strobe |
| lane_pair_rst_o | output | N_PAIR | Lane-pair reset strobes |
| dyn_wr_o | output | 1 | Control word write strobe |
| dyn_word_o | output | 15 | Control word (bits 6:0 hold, 10 calibrator, 13/14 lanes) |
| cal_rst_o | output | 1 | Calibrator soft-reset pulse |
| cal_lock_o | output | 1 | Calibration lock, sticky |
| pll_cfg_o | output | 1 | PLL and clock-mux setup strobe |
| mac_mode_o | output | 2*N_MAC | Per-MAC gigabit and ten-bit mode bits |
| thr_wr_o | output | 1 | Threshold write strobe |
| thr_late_o | output | 3*N_CH | Late eye threshold per channel |
| thr_early_o | output | 3*N_CH | Early eye threshold per channel |
| variant_o | output | 2 | Silicon class: 0 none, 1 slow, 2 typical, 3 newer |
| setup_done_o | output | 1 | Setup finished, sticky |

## Verification
The bench aims at both sides of each classification boundary: codes 12 and 13 with the revision flag clear, and a low code with the flag set. A classifier with an off-by-one compare, or one that ignores the flag, would write the wrong threshold pair. On newer silicon it drives a pcode equal to the threshold and one just above it. A design that used greater-or-equal would skip the alternate pair and the second lane reset, and a wrong settle count would move the check away from 4096 cycles after the lane reset. Held-low status flags and a tick that toggles every other cycle expose a design that steps past a wait or takes a step without a tick.

// File: rtl/sgmii_bringup_pkg.sv
package sgmii_bringup_pkg;

    localparam int SR_W          = 9;
    localparam int DYN_W         = 15;
    localparam int CODE_W        = 7;
    localparam int THR_W         = 3;
    localparam int SR_NV_BIT     = 0;
    localparam int SR_PERIPH_BIT = 8;
    localparam int DYN_CAL_BIT   = 10;
    localparam int DYN_LANE0_BIT = 13;
    localparam int DYN_LANE1_BIT = 14;
    localparam logic [6:0] DYN_HOLD = 7'h7F;

    typedef enum logic [4:0] {
        ST_START,
        ST_OFF_SR_A, ST_OFF_SR_B, ST_OFF_CFG, ST_OFF_DLL,
        ST_INIT_SR_A, ST_INIT_SR_B, ST_INIT_CFG,
        ST_WAIT_IOEN, ST_RAMP,
        ST_IO_DLL, ST_IO_PVT_A, ST_IO_PVT_B, ST_IO_CAL,
        ST_WAIT_CAL, ST_CAL_LOCK, ST_PLL_SET, ST_WAIT_PLL, ST_WAIT_DLL,
        ST_MAC_ON, ST_CLASSIFY, ST_LANE_A, ST_LANE_B,
        ST_SETTLE, ST_CHECK, ST_UP
    } seq_state_t;

    typedef enum logic [1:0] {
        VAR_NONE = 2'd0,
        VAR_SLOW = 2'd1,
        VAR_TYP  = 2'd2,
        VAR_NEW  = 2'd3
    } variant_t;

    typedef struct packed {
        logic [THR_W-1:0] late;
        logic [THR_W-1:0] early;
    } thr_pair_t;

    typedef struct packed {
        logic             sr_wr;
        logic             cfg_load;
        logic             dll_rst;
        logic             lane_pair;
        logic             dyn_wr;
        logic             cal_rst;
        logic             pll_cfg;
        logic             thr_cls;
        logic             thr_alt;
        logic             mac_on;
        logic             lock_set;
        logic [SR_W-1:0]  sr_word;
        logic [DYN_W-1:0] dyn_word;
    } seq_act_t;

    function automatic logic [SR_W-1:0] mk_sr(input logic periph);
        logic [SR_W-1:0] w;
        w                = '0;
        w[SR_NV_BIT]     = 1'b1;
        w[SR_PERIPH_BIT] = periph;
        return w;
    endfunction

    function automatic logic [DYN_W-1:0] mk_dyn(input logic cal, input logic lanes);
        logic [DYN_W-1:0] w;
        w                = '0;
        w[6:0]           = DYN_HOLD;
        w[DYN_CAL_BIT]   = cal;
        w[DYN_LANE0_BIT] = lanes;
        w[DYN_LANE1_BIT] = lanes;
        return w;
    endfunction

    function automatic variant_t classify(input logic rev, input logic [CODE_W-1:0] code,
                                          input logic [CODE_W-1:0] min_typ);
        if (rev)                return VAR_NEW;
        else if (code < min_typ) return VAR_SLOW;
        else                     return VAR_TYP;
    endfunction

endpackage

// File: rtl/sgmii_step_timer.sv
module sgmii_step_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && tick_i && ((cnt_q + CNT_W'(1)) == limit_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= expire_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sgmii_variant_sel.sv
module sgmii_variant_sel
    import sgmii_bringup_pkg::*;
#(
    parameter int               N_CH         = 2,
    parameter int               PCODE_W      = 8,
    parameter logic [PCODE_W-1:0] PCODE_THR  = 8'd40,
    parameter logic [CODE_W-1:0] MIN_TYP_CODE = 7'd13,
    parameter logic [THR_W-1:0] SLOW_LATE    = 3'd2,
    parameter logic [THR_W-1:0] SLOW_EARLY   = 3'd5,
    parameter logic [THR_W-1:0] TYP_LATE     = 3'd4,
    parameter logic [THR_W-1:0] TYP_EARLY    = 3'd3,
    parameter logic [THR_W-1:0] NEWPRE_LATE  = 3'd6,
    parameter logic [THR_W-1:0] NEWPRE_EARLY = 3'd1,
    parameter logic [THR_W-1:0] NEWALT_LATE  = 3'd7,
    parameter logic [THR_W-1:0] NEWALT_EARLY = 3'd2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cls_load_i,
    input  logic                    alt_load_i,
    input  logic                    rev_new_i,
    input  logic [CODE_W-1:0]       dll_code_i,
    input  logic [PCODE_W-1:0]      pcode_i,
    output variant_t                variant_o,
    output logic                    is_new_o,
    output logic                    pcode_ok_o,
    output logic [THR_W*N_CH-1:0]   thr_late_o,
    output logic [THR_W*N_CH-1:0]   thr_early_o
);

    variant_t  variant_q;
    variant_t  cls_now;
    thr_pair_t pair_q;
    thr_pair_t pair_pick;

    assign cls_now    = classify(rev_new_i, dll_code_i, MIN_TYP_CODE);
    assign pcode_ok_o = pcode_i > PCODE_THR;
    assign is_new_o   = (variant_q == VAR_NEW);
    assign variant_o  = variant_q;

    always_comb begin
        case (cls_now)
            VAR_SLOW: pair_pick = '{late: SLOW_LATE,   early: SLOW_EARLY};
            VAR_TYP:  pair_pick = '{late: TYP_LATE,    early: TYP_EARLY};
            VAR_NEW:  pair_pick = '{late: NEWPRE_LATE, early: NEWPRE_EARLY};
            default:  pair_pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            variant_q <= VAR_NONE;
            pair_q    <= '0;
        end else if (cls_load_i) begin
            variant_q <= cls_now;
            pair_q    <= pair_pick;
        end else if (alt_load_i) begin
            pair_q    <= '{late: NEWALT_LATE, early: NEWALT_EARLY};
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign thr_late_o[THR_W*c +: THR_W]  = pair_q.late;
        assign thr_early_o[THR_W*c +: THR_W] = pair_q.early;
    end

endmodule

// File: rtl/sgmii_seq_fsm.sv
module sgmii_seq_fsm
    import sgmii_bringup_pkg::*;
#(
    parameter int CHEN_W       = 4,
    parameter int CNT_W        = 12,
    parameter int RAMP_TICKS   = 15,
    parameter int SETTLE_TICKS = 4095
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [CHEN_W-1:0] chan_en_i,
    input  logic              io_en_i,
    input  logic              cal_done_i,
    input  logic              pll_lock_i,
    input  logic              dll_lock_i,
    input  logic              is_new_i,
    input  logic              pcode_ok_i,
    input  logic              tmr_expire_i,
    output logic              tmr_run_o,
    output logic [CNT_W-1:0]  tmr_limit_o,
    output logic              done_o,
    output seq_act_t          act_o
);

    seq_state_t st_q, st_nxt;
    logic       redo_q;

    assign tmr_run_o   = (st_q == ST_RAMP) || (st_q == ST_SETTLE);
    assign tmr_limit_o = (st_q == ST_SETTLE) ? CNT_W'(SETTLE_TICKS) : CNT_W'(RAMP_TICKS);
    assign done_o      = (st_q == ST_UP);

    always_comb begin
        st_nxt = st_q;
        act_o  = '0;
        if (tick_i) begin
            case (st_q)
                ST_START:     st_nxt = (|chan_en_i) ? ST_INIT_SR_A : ST_OFF_SR_A;
                ST_OFF_SR_A: begin
                    act_o.sr_wr   = 1'b1;
                    act_o.sr_word = mk_sr(1'b1);
                    st_nxt        = ST_OFF_SR_B;
                end
                ST_OFF_SR_B: begin
                    act_o.sr_wr   = 1'b1;
                    act_o.sr_word = mk_sr(1'b0);
                    st_nxt        = ST_OFF_CFG;
                end
                ST_OFF_CFG: begin
                    act_o.cfg_load = 1'b1;
                    st_nxt         = ST_OFF_DLL;
                end
                ST_OFF_DLL: begin
                    act_o.dll_rst = 1'b1;
                    st_nxt        = ST_UP;
                end
                ST_INIT_SR_A: begin
                    act_o.sr_wr   = 1'b1;
                    act_o.sr_word = mk_sr(1'b1);
                    st_nxt        = ST_INIT_SR_B;
                end
                ST_INIT_SR_B: begin
                    act_o.sr_wr   = 1'b1;
                    act_o.sr_word = mk_sr(1'b0);
                    st_nxt        = ST_INIT_CFG;
                end
                ST_INIT_CFG: begin
                    act_o.cfg_load = 1'b1;
                    st_nxt         = ST_WAIT_IOEN;
                end
                ST_WAIT_IOEN: if (io_en_i) st_nxt = ST_RAMP;
                ST_RAMP:      if (tmr_expire_i) st_nxt = ST_IO_DLL;
                ST_IO_DLL: begin
                    act_o.dll_rst   = 1'b1;
                    act_o.lane_pair = 1'b1;
                    st_nxt          = ST_IO_PVT_A;
                end
                ST_IO_PVT_A: begin
                    act_o.dyn_wr   = 1'b1;
                    act_o.dyn_word = mk_dyn(1'b1, 1'b0);
                    st_nxt         = ST_IO_PVT_B;
                end
                ST_IO_PVT_B: begin
                    act_o.dyn_wr   = 1'b1;
                    act_o.dyn_word = mk_dyn(1'b0, 1'b0);
                    st_nxt         = ST_IO_CAL;
                end
                ST_IO_CAL: begin
                    act_o.cal_rst = 1'b1;
                    st_nxt        = ST_WAIT_CAL;
                end
                ST_WAIT_CAL:  if (cal_done_i) st_nxt = ST_CAL_LOCK;
                ST_CAL_LOCK: begin
                    act_o.lock_set = 1'b1;
                    st_nxt         = ST_PLL_SET;
                end
                ST_PLL_SET: begin
                    act_o.pll_cfg = 1'b1;
                    st_nxt        = ST_WAIT_PLL;
                end
                ST_WAIT_PLL:  if (pll_lock_i) st_nxt = ST_WAIT_DLL;
                ST_WAIT_DLL:  if (dll_lock_i) st_nxt = ST_MAC_ON;
                ST_MAC_ON: begin
                    act_o.mac_on = 1'b1;
                    st_nxt       = ST_CLASSIFY;
                end
                ST_CLASSIFY: begin
                    act_o.thr_cls = 1'b1;
                    st_nxt        = ST_LANE_A;
                end
                ST_LANE_A: begin
                    act_o.dyn_wr   = 1'b1;
                    act_o.dyn_word = mk_dyn(1'b0, 1'b1);
                    st_nxt         = ST_LANE_B;
                end
                ST_LANE_B: begin
                    act_o.dyn_wr   = 1'b1;
                    act_o.dyn_word = mk_dyn(1'b0, 1'b0);
                    st_nxt         = (is_new_i && !redo_q) ? ST_SETTLE : ST_UP;
                end
                ST_SETTLE:    if (tmr_expire_i) st_nxt = ST_CHECK;
                ST_CHECK: begin
                    if (pcode_ok_i) begin
                        st_nxt = ST_UP;
                    end else begin
                        act_o.thr_alt = 1'b1;
                        st_nxt        = ST_LANE_A;
                    end
                end
                ST_UP:        st_nxt = ST_UP;
                default:      st_nxt = ST_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_START;
            redo_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (act_o.thr_alt) redo_q <= 1'b1;
        end
    end

endmodule

// File: rtl/sgmii_bringup_seq.sv
module sgmii_bringup_seq
    import sgmii_bringup_pkg::*;
#(
    parameter int N_CH         = 2,
    parameter int N_PAIR       = 2,
    parameter int N_MAC        = 2,
    parameter int CHEN_W       = 4,
    parameter int PCODE_W      = 8,
    parameter int PCODE_THR    = 40,
    parameter int MIN_TYP_CODE = 13,
    parameter int RAMP_TICKS   = 15,
    parameter int SETTLE_TICKS = 4095
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic [CHEN_W-1:0]       chan_en_i,
    input  logic                    io_en_i,
    input  logic                    cal_done_i,
    input  logic                    pll_lock_i,
    input  logic                    dll_lock_i,
    input  logic [6:0]              dll_code_i,
    input  logic                    rev_new_i,
    input  logic [PCODE_W-1:0]      ref_pcode_i,
    output logic                    sr_wr_o,
    output logic [8:0]              sr_word_o,
    output logic                    cfg_load_o,
    output logic                    dll_rst_o,
    output logic [N_PAIR-1:0]       lane_pair_rst_o,
    output logic                    dyn_wr_o,
    output logic [14:0]             dyn_word_o,
    output logic                    cal_rst_o,
    output logic                    cal_lock_o,
    output logic                    pll_cfg_o,
    output logic [2*N_MAC-1:0]      mac_mode_o,
    output logic                    thr_wr_o,
    output logic [3*N_CH-1:0]       thr_late_o,
    output logic [3*N_CH-1:0]       thr_early_o,
    output logic [1:0]              variant_o,
    output logic                    setup_done_o
);

    localparam int MAX_WAIT = (SETTLE_TICKS > RAMP_TICKS) ? SETTLE_TICKS : RAMP_TICKS;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    seq_act_t         act;
    logic             tmr_run, tmr_expire;
    logic [CNT_W-1:0] tmr_limit;
    logic             is_new, pcode_ok;
    variant_t         variant;
    logic             cal_lock_q, mac_q;

    sgmii_seq_fsm #(
        .CHEN_W       (CHEN_W),
        .CNT_W        (CNT_W),
        .RAMP_TICKS   (RAMP_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .chan_en_i    (chan_en_i),
        .io_en_i      (io_en_i),
        .cal_done_i   (cal_done_i),
        .pll_lock_i   (pll_lock_i),
        .dll_lock_i   (dll_lock_i),
        .is_new_i     (is_new),
        .pcode_ok_i   (pcode_ok),
        .tmr_expire_i (tmr_expire),
        .tmr_run_o    (tmr_run),
        .tmr_limit_o  (tmr_limit),
        .done_o       (setup_done_o),
        .act_o        (act)
    );

    sgmii_step_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (tmr_run),
        .tick_i   (tick_i),
        .limit_i  (tmr_limit),
        .expire_o (tmr_expire)
    );

    sgmii_variant_sel #(
        .N_CH         (N_CH),
        .PCODE_W      (PCODE_W),
        .PCODE_THR    (PCODE_W'(PCODE_THR)),
        .MIN_TYP_CODE (CODE_W'(MIN_TYP_CODE))
    ) u_variant (
        .clk         (clk),
        .rst         (rst),
        .cls_load_i  (act.thr_cls),
        .alt_load_i  (act.thr_alt),
        .rev_new_i   (rev_new_i),
        .dll_code_i  (dll_code_i),
        .pcode_i     (ref_pcode_i),
        .variant_o   (variant),
        .is_new_o    (is_new),
        .pcode_ok_o  (pcode_ok),
        .thr_late_o  (thr_late_o),
        .thr_early_o (thr_early_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_lock_q <= 1'b0;
            mac_q      <= 1'b0;
        end else begin
            if (act.lock_set) cal_lock_q <= 1'b1;
            if (act.mac_on)   mac_q      <= 1'b1;
        end
    end

    for (genvar m = 0; m < N_MAC; m++) begin : g_mac
        assign mac_mode_o[2*m +: 2] = {mac_q, mac_q};
    end

    assign sr_wr_o         = act.sr_wr;
    assign sr_word_o       = act.sr_word;
    assign cfg_load_o      = act.cfg_load;
    assign dll_rst_o       = act.dll_rst;
    assign lane_pair_rst_o = {N_PAIR{act.lane_pair}};
    assign dyn_wr_o        = act.dyn_wr;
    assign dyn_word_o      = act.dyn_word;
    assign cal_rst_o       = act.cal_rst;
    assign cal_lock_o      = cal_lock_q;
    assign pll_cfg_o       = act.pll_cfg;
    assign thr_wr_o        = act.thr_cls | act.thr_alt;
    assign variant_o       = variant;

endmodule

// File: rtl/sgmii_bringup_chk.sv
module sgmii_bringup_chk #(
    parameter int N_PAIR = 2,
    parameter int N_MAC  = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                tick_i,
    input logic                sr_wr_o,
    input logic                cfg_load_o,
    input logic                dll_rst_o,
    input logic [N_PAIR-1:0]   lane_pair_rst_o,
    input logic                dyn_wr_o,
    input logic                cal_rst_o,
    input logic                cal_lock_o,
    input logic                pll_cfg_o,
    input logic [2*N_MAC-1:0]  mac_mode_o,
    input logic                thr_wr_o,
    input logic [1:0]          variant_o,
    input logic                setup_done_o
);

    logic any_strobe;
    assign any_strobe = sr_wr_o | cfg_load_o | dll_rst_o | (|lane_pair_rst_o) |
                        dyn_wr_o | cal_rst_o | pll_cfg_o | thr_wr_o;

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick_i |-> !any_strobe); // R12

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sr_wr_o, cfg_load_o, dyn_wr_o, cal_rst_o, pll_cfg_o, thr_wr_o})); // R12

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        setup_done_o |=> setup_done_o); // R11

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        setup_done_o |-> !any_strobe); // R11

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        cal_lock_o |=> cal_lock_o); // R6

    AST_PLL_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        pll_cfg_o |-> cal_lock_o); // R6

    AST_THR_AFTER_MAC: assert property (@(posedge clk) disable iff (rst)
        thr_wr_o |-> (&mac_mode_o)); // R6

    AST_VARIANT_SET: assert property (@(posedge clk) disable iff (rst)
        thr_wr_o |=> (variant_o != 2'd0)); // R7

endmodule

bind sgmii_bringup_seq sgmii_bringup_chk #(
    .N_PAIR (N_PAIR),
    .N_MAC  (N_MAC)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .tick_i          (tick_i),
    .sr_wr_o         (sr_wr_o),
    .cfg_load_o      (cfg_load_o),
    .dll_rst_o       (dll_rst_o),
    .lane_pair_rst_o (lane_pair_rst_o),
    .dyn_wr_o        (dyn_wr_o),
    .cal_rst_o       (cal_rst_o),
    .cal_lock_o      (cal_lock_o),
    .pll_cfg_o       (pll_cfg_o),
    .mac_mode_o      (mac_mode_o),
    .thr_wr_o        (thr_wr_o),
    .variant_o       (variant_o),
    .setup_done_o    (setup_done_o)
);

// File: tb/sgmii_bringup_seq_bench.sv
module sgmii_bringup_seq_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] F_SR   = 8'h80;
    localparam logic [7:0] F_CFG  = 8'h40;
    localparam logic [7:0] F_DLL  = 8'h20;
    localparam logic [7:0] F_LANE = 8'h10;
    localparam logic [7:0] F_DYN  = 8'h08;
    localparam logic [7:0] F_CAL  = 8'h04;
    localparam logic [7:0] F_PLL  = 8'h02;
    localparam logic [7:0] F_THR  = 8'h01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b1;
    logic [3:0]  chan_en_i = '0;
    logic        io_en_i = 1'b0, cal_done_i = 1'b0, pll_lock_i = 1'b0, dll_lock_i = 1'b0;
    logic [6:0]  dll_code_i = '0;
    logic        rev_new_i = 1'b0;
    logic [7:0]  ref_pcode_i = '0;
    logic        sr_wr_o, cfg_load_o, dll_rst_o, dyn_wr_o, cal_rst_o, cal_lock_o;
    logic        pll_cfg_o, thr_wr_o, setup_done_o;
    logic [8:0]  sr_word_o;
    logic [1:0]  lane_pair_rst_o;
    logic [14:0] dyn_word_o;
    logic [3:0]  mac_mode_o;
    logic [5:0]  thr_late_o, thr_early_o;
    logic [1:0]  variant_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int done_cyc = -1;
    int ioen_cyc = 0;
    bit tick_alt = 1'b0;
    logic [31:0] exp_q[$];
    string       exp_req[$];
    int          got_cyc[$];

    sgmii_bringup_seq u_sgmii_bringup_seq (
        .clk(clk), .rst(rst), .tick_i(tick_i), .chan_en_i(chan_en_i),
        .io_en_i(io_en_i), .cal_done_i(cal_done_i), .pll_lock_i(pll_lock_i),
        .dll_lock_i(dll_lock_i), .dll_code_i(dll_code_i), .rev_new_i(rev_new_i),
        .ref_pcode_i(ref_pcode_i), .sr_wr_o(sr_wr_o), .sr_word_o(sr_word_o),
        .cfg_load_o(cfg_load_o), .dll_rst_o(dll_rst_o), .lane_pair_rst_o(lane_pair_rst_o),
        .dyn_wr_o(dyn_wr_o), .dyn_word_o(dyn_word_o), .cal_rst_o(cal_rst_o),
        .cal_lock_o(cal_lock_o), .pll_cfg_o(pll_cfg_o), .mac_mode_o(mac_mode_o),
        .thr_wr_o(thr_wr_o), .thr_late_o(thr_late_o), .thr_early_o(thr_early_o),
        .variant_o(variant_o), .setup_done_o(setup_done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [7:0] f, input logic [23:0] p, input string r);
        exp_q.push_back({f, p});
        exp_req.push_back(r);
    endtask

    // tick generator
    initial begin
        forever begin
            @(negedge clk);
            tick_i = tick_alt ? ~tick_i : 1'b1;
        end
    end

    // monitor: pops the scoreboard as strobes appear
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            cyc++;
            if (!rst) begin
                if (sr_wr_o || cfg_load_o || dll_rst_o || (|lane_pair_rst_o) || dyn_wr_o ||
                    cal_rst_o || pll_cfg_o || thr_wr_o) begin
                    logic [7:0]  f;
                    logic [23:0] p;
                    logic [31:0] ev, e;
                    string       r;
                    f = {sr_wr_o, cfg_load_o, dll_rst_o, |lane_pair_rst_o, dyn_wr_o,
                         cal_rst_o, pll_cfg_o, thr_wr_o};
                    p = sr_wr_o ? 24'(sr_word_o) : dyn_wr_o ? 24'(dyn_word_o) :
                        (|lane_pair_rst_o) ? 24'(lane_pair_rst_o) : 24'h0;
                    ev = {f, p};
                    got_cyc.push_back(cyc);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R12", "unexpected event", ev, 0);
                    end else begin
                        e = exp_q.pop_front();
                        r = exp_req.pop_front();
                        check(ev == e, r, "event", ev, e);
                    end
                end
                if (setup_done_o && done_cyc < 0) done_cyc = cyc;
            end
        end
    end

    task automatic run_case(input bit en, input bit rev, input logic [6:0] code,
                            input logic [7:0] pcode, input bit alt,
                            input int exp_var, input logic [2:0] exp_late,
                            input logic [2:0] exp_early, input bit redo);
        @(negedge clk);
        rst = 1'b1;
        io_en_i = 1'b0; cal_done_i = 1'b0; pll_lock_i = 1'b0; dll_lock_i = 1'b0;
        chan_en_i   = en ? 4'b0100 : 4'b0000;
        rev_new_i   = rev;
        dll_code_i  = code;
        ref_pcode_i = pcode;
        tick_alt    = alt;
        repeat (3) @(negedge clk);
        exp_q.delete(); exp_req.delete(); got_cyc.delete();
        done_cyc = -1;
        #1;
        check(setup_done_o == 1'b0, "R1", "done in reset", setup_done_o, 0);
        check(cal_lock_o == 1'b0 && mac_mode_o == 4'h0, "R1", "lock/mac in reset",
              {cal_lock_o, mac_mode_o}, 0);
        check(thr_late_o == 6'h0 && thr_early_o == 6'h0 && variant_o == 2'd0, "R1",
              "thresholds in reset", {variant_o, thr_late_o, thr_early_o}, 0);
        check(!(sr_wr_o || cfg_load_o || dll_rst_o || dyn_wr_o || thr_wr_o), "R1",
              "strobes in reset", {sr_wr_o, cfg_load_o, dll_rst_o, dyn_wr_o, thr_wr_o}, 0);
        if (!en) begin
            expect_ev(F_SR, 24'h101, "R2");
            expect_ev(F_SR, 24'h001, "R2");
            expect_ev(F_CFG, 24'h0, "R2");
            expect_ev(F_DLL, 24'h0, "R2");
        end else begin
            expect_ev(F_SR, 24'h101, "R3");
            expect_ev(F_SR, 24'h001, "R3");
            expect_ev(F_CFG, 24'h0, "R3");
            expect_ev(F_DLL | F_LANE, 24'h3, "R5");
            expect_ev(F_DYN, 24'h047F, "R5");
            expect_ev(F_DYN, 24'h007F, "R5");
            expect_ev(F_CAL, 24'h0, "R5");
            expect_ev(F_PLL, 24'h0, "R6");
            expect_ev(F_THR, 24'h0, "R7");
            expect_ev(F_DYN, 24'h607F, "R8");
            expect_ev(F_DYN, 24'h007F, "R8");
            if (redo) begin
                expect_ev(F_THR, 24'h0, "R10");
                expect_ev(F_DYN, 24'h607F, "R10");
                expect_ev(F_DYN, 24'h007F, "R10");
            end
        end
        @(negedge clk);
        rst = 1'b0;
        if (en) begin
            repeat (8) @(negedge clk);
            check(got_cyc.size() == 3, "R3", "events before io enable", got_cyc.size(), 3);
            io_en_i  = 1'b1;
            ioen_cyc = cyc + 1;
            repeat (40) @(negedge clk);
            cal_done_i = 1'b1;
            repeat (8) @(negedge clk);
            check(cal_lock_o == 1'b1, "R6", "calibration lock", cal_lock_o, 1);
            pll_lock_i = 1'b1;
            repeat (8) @(negedge clk);
            check(got_cyc.size() == 8 && mac_mode_o == 4'h0, "R6", "hold before DLL lock",
                  {got_cyc.size(), mac_mode_o}, 32'h80);
            dll_lock_i = 1'b1;
        end
        for (int i = 0; i < 20000 && !setup_done_o; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(setup_done_o == 1'b1, "R11", "done reached and held", setup_done_o, 1);
        check(exp_q.size() == 0, "R11", "events left unseen", exp_q.size(), 0);
        if (!en) begin
            check(cal_lock_o == 1'b0 && mac_mode_o == 4'h0, "R2", "off path outputs",
                  {cal_lock_o, mac_mode_o}, 0);
        end else begin
            check(mac_mode_o == 4'hF, "R6", "mac mode bits", mac_mode_o, 4'hF);
            check(variant_o == 2'(exp_var), "R7", "variant", variant_o, exp_var);
            check(thr_late_o == {exp_late, exp_late}, redo ? "R10" : "R7", "late thresholds",
                  thr_late_o, {exp_late, exp_late});
            check(thr_early_o == {exp_early, exp_early}, redo ? "R10" : "R7", "early thresholds",
                  thr_early_o, {exp_early, exp_early});
            if (!alt && got_cyc.size() >= 11) begin
                check(got_cyc[3] - ioen_cyc == 16, "R4", "ramp length",
                      got_cyc[3] - ioen_cyc, 16);
                if (exp_var != 3) begin
                    check(done_cyc - got_cyc[10] == 1, "R9", "done after lane reset",
                          done_cyc - got_cyc[10], 1);
                end else if (!redo) begin
                    check(done_cyc - got_cyc[10] == 4097, "R10", "settle then done",
                          done_cyc - got_cyc[10], 4097);
                end else if (got_cyc.size() >= 14) begin
                    check(got_cyc[11] - got_cyc[10] == 4096, "R10", "settle then check",
                          got_cyc[11] - got_cyc[10], 4096);
                    check(done_cyc - got_cyc[13] == 1, "R10", "done after second lane reset",
                          done_cyc - got_cyc[13], 1);
                end
            end
        end
    endtask

    initial begin
        run_case(1'b0, 1'b0, 7'd0,   8'd0,  1'b0, 0, 3'd0, 3'd0, 1'b0); // R2 off path
        run_case(1'b1, 1'b0, 7'd12,  8'd0,  1'b0, 1, 3'd2, 3'd5, 1'b0); // R7 slow corner
        run_case(1'b1, 1'b0, 7'd13,  8'd0,  1'b0, 2, 3'd4, 3'd3, 1'b0); // R7 typical edge
        run_case(1'b1, 1'b1, 7'd5,   8'd41, 1'b0, 3, 3'd6, 3'd1, 1'b0); // R10 pass
        run_case(1'b1, 1'b1, 7'd100, 8'd40, 1'b0, 3, 3'd7, 3'd2, 1'b1); // R10 equal -> redo
        run_case(1'b1, 1'b0, 7'd127, 8'd0,  1'b1, 2, 3'd4, 3'd3, 1'b0); // R12 sparse ticks
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule